// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between the control/status registers of a memory controller and its SDRAM command generator. It owns the SDRAM power state. A self-refresh request can come from a software control bit or from a power-management handshake line, and the two are ORed. The block then closes any open access and issues precharge-all. It follows with the self-refresh command, with clock enable dropped, and raises an acknowledge bit that software or the power manager can poll. A deep-sleep request takes the device to deep power-down instead. In that state no refresh runs and the contents are treated as lost.

During normal operation the block paces periodic auto-refresh from a row-count selection, and this pacing keeps running while a soft reset is asserted. Dynamic accesses are granted only when the sequencer is idle, initialised and out of soft reset. Static accesses are granted in every state. After deep power-down a flag requests the full SDRAM initialisation sequence, and dynamic grants stay blocked until that sequence is reported done.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, cke_o is 1, cmd_o is NOP (0), sr_ack_o is 0, init_req_o is 1 and dyn_gnt_o is 0.
- R2: A self-refresh request from sw_sr_req_i or pmu_sr_req_i, seen while idle, leads to the following in order. First, one or more wait cycles that last while dyn_busy_i is high. Second, one cycle of PRECHARGE_ALL (1). Third, one cycle of SELF_REFRESH (3) with cke_o low. After that sr_ack_o goes high with cke_o still low. Both request sources act the same way.
- R3: If deep-sleep and self-refresh are both requested when the idle state is left, the deep power-down path is taken: DEEP_PD (4) is issued and sr_ack_o never rises.
- R4: When both self-refresh request sources are low, cke_o rises in the next cycle. AUTO_REFRESH (2) is issued exactly exit_wait_i+1 cycles after the cycle in which cke_o rises.
- R5: In deep power-down, cke_o stays low, no AUTO_REFRESH is issued and sr_ack_o stays low. When deep_sleep_i falls, cke_o rises and init_req_o is set. It stays set, and dyn_gnt_o stays low, until init_done_i is pulsed.
- R6: st_gnt_o equals st_req_i in every state, including self-refresh and deep power-down.
- R7: dyn_gnt_o is high only when all of the following hold: the sequencer is idle, dyn_req_i is high, init_req_o is low, soft_rst_i is low, no refresh is issued in that cycle and no low-power entry starts in that cycle.
- R8: While idle and unblocked, AUTO_REFRESH repeats every (REF_WINDOW/2048)>>k cycles. k is given by row_sel_i: 0 selects 2K rows (k=0), 1 selects 4K rows (k=1), and 2 or 3 selects 8K rows (k=2).
- R9: While soft_rst_i is high, periodic AUTO_REFRESH continues at the R8 rate, dyn_gnt_o stays low and low-power requests are ignored.
- R10: A due refresh is held while dyn_busy_i is high and is issued in the first idle cycle in which dyn_busy_i is low. A refresh takes precedence over a dynamic grant.
- R11: sr_ack_o stays high through the exit wait and the exit AUTO_REFRESH cycle, and falls in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| soft_rst_i | input | 1 | Soft reset: blocks grants and entries, refresh continues |
| sw_sr_req_i | input | 1 | Self-refresh request from the software control bit |
| pmu_sr_req_i | input | 1 | Self-refresh request from the power manager |
| deep_sleep_i | input | 1 | Deep power-down request |
| exit_wait_i | input | EXIT_W | Exit recovery count |
| row_sel_i | input | 2 | Row count select (0=2K, 1=4K, 2/3=8K) |
| init_done_i | input | 1 | Initialisation sequence finished |
| dyn_req_i | input | 1 | Dynamic access request |
| dyn_busy_i | input | 1 | A dynamic access is open |
| st_req_i | input | 1 | Static access request |
| dyn_gnt_o | output | 1 | Dynamic access grant |
| st_gnt_o | output | 1 | Static access grant |
| cmd_o | output | 3 | SDRAM command (0 NOP, 1 PRECHARGE_ALL, 2 AUTO_REFRESH, 3 SELF_REFRESH, 4 DEEP_PD) |
| cke_o | output | 1 | SDRAM clock enable |
| sr_ack_o | output | 1 | Self-refresh acknowledge status |
| init_req_o | output | 1 | Full initialisation required |

## Verification
The assertions check the following on every cycle:
- SELF_REFRESH always follows PRECHARGE_ALL.
- The acknowledge rises only just after the self-refresh command, with clock enable low.
- Clock enable returns with the acknowledge still high only when no request is present.
- No refresh and no dynamic grant occur while the device is powered down or initialisation is pending.

Only the bench scenarios can show the timing-dependent behaviour: the refresh spacing for each row selection, the exit-recovery distance, deep-sleep priority over a simultaneous self-refresh request, refresh continuing under soft reset, and a refresh being held back by an open access.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_PRE_ALL = 3'd1,
    CMD_AREF    = 3'd2,
    CMD_SREF    = 3'd3,
    CMD_DPD     = 3'd4
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_PRE,
    ST_SR_CMD,
    ST_SR,
    ST_SR_EXIT,
    ST_SR_AREF,
    ST_DP_CMD,
    ST_DP
  } pwr_st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_WINDOW = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       fire_i,
  input  logic [1:0] row_sel_i,
  output logic       pend_o
);
  localparam int BASE = REF_WINDOW / 2048;
  localparam int TW   = $clog2(BASE + 1);

  logic [TW-1:0] tmr_q, intv;
  logic          pend_q, due;

  always_comb begin
    case (row_sel_i)
      2'd0:    intv = TW'(BASE);
      2'd1:    intv = TW'(BASE >> 1);
      default: intv = TW'(BASE >> 2);
    endcase
  end

  // >= so a shorter interval picked mid-count still wraps
  assign due = tmr_q >= (intv - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else if (!run_i) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      tmr_q <= due ? '0 : tmr_q + TW'(1);
      if (due)         pend_q <= 1'b1;
      else if (fire_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R8
  pend_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(run_i));
endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
  import sdram_pwr_pkg::*;
#(
  parameter int EXIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sr_req_i,
  input  logic              deep_i,
  input  logic              busy_i,
  input  logic [EXIT_W-1:0] exit_wait_i,
  input  logic              ref_pend_i,
  input  logic              init_done_i,
  output sd_cmd_e           cmd_o,
  output logic              cke_o,
  output logic              ack_o,
  output logic              run_o,
  output logic              fire_o,
  output logic              start_o,
  output logic              idle_o,
  output logic              init_req_o
);
  pwr_st_e           st_q, st_d;
  logic              tgt_dp_q, tgt_dp_d;
  logic [EXIT_W-1:0] cnt_q, cnt_d;
  logic              init_q;

  assign idle_o  = st_q == ST_IDLE;
  assign fire_o  = idle_o && ref_pend_i && !busy_i;
  assign start_o = idle_o && !soft_rst_i && (deep_i || sr_req_i);
  assign run_o   = st_q inside {ST_IDLE, ST_DRAIN, ST_PRE};

  always_comb begin
    st_d     = st_q;
    tgt_dp_d = tgt_dp_q;
    cnt_d    = cnt_q;
    case (st_q)
      ST_IDLE: if (start_o) begin
        st_d     = ST_DRAIN;
        tgt_dp_d = deep_i;  // deep sleep wins
      end
      ST_DRAIN:   if (!busy_i) st_d = ST_PRE;
      ST_PRE:     st_d = tgt_dp_q ? ST_DP_CMD : ST_SR_CMD;
      ST_SR_CMD:  st_d = ST_SR;
      ST_SR: if (!sr_req_i) begin
        st_d  = ST_SR_EXIT;
        cnt_d = '0;
      end
      ST_SR_EXIT: begin
        if (cnt_q == exit_wait_i) st_d = ST_SR_AREF;
        else cnt_d = cnt_q + EXIT_W'(1);
      end
      ST_SR_AREF: st_d = ST_IDLE;
      ST_DP_CMD:  st_d = ST_DP;
      ST_DP:      if (!deep_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tgt_dp_q <= 1'b0;
      cnt_q    <= '0;
      init_q   <= 1'b1;
    end else begin
      st_q     <= st_d;
      tgt_dp_q <= tgt_dp_d;
      cnt_q    <= cnt_d;
      if (st_q == ST_DP && !deep_i) init_q <= 1'b1;
      else if (init_done_i)         init_q <= 1'b0;
    end
  end

  always_comb begin
    case (st_q)
      ST_PRE:     cmd_o = CMD_PRE_ALL;
      ST_SR_CMD:  cmd_o = CMD_SREF;
      ST_SR_AREF: cmd_o = CMD_AREF;
      ST_DP_CMD:  cmd_o = CMD_DPD;
      ST_IDLE:    cmd_o = fire_o ? CMD_AREF : CMD_NOP;
      default:    cmd_o = CMD_NOP;
    endcase
  end

  assign cke_o      = !(st_q inside {ST_SR_CMD, ST_SR, ST_DP_CMD, ST_DP});
  assign ack_o      = st_q inside {ST_SR, ST_SR_EXIT, ST_SR_AREF};
  assign init_req_o = init_q;

  // R4
  exit_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SR_EXIT) |-> cnt_q <= exit_wait_i);
endmodule

// File: rtl/sdram_grant_gate.sv
module sdram_grant_gate (
  input  logic idle_i,
  input  logic fire_i,
  input  logic start_i,
  input  logic init_req_i,
  input  logic soft_rst_i,
  input  logic dyn_req_i,
  input  logic st_req_i,
  output logic dyn_gnt_o,
  output logic st_gnt_o
);
  assign dyn_gnt_o = idle_i && dyn_req_i && !init_req_i && !soft_rst_i
                     && !fire_i && !start_i;
  // static bus is independent of SDRAM power state
  assign st_gnt_o  = st_req_i;
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int REF_WINDOW = 65536,
  parameter int EXIT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              sw_sr_req_i,
  input  logic              pmu_sr_req_i,
  input  logic              deep_sleep_i,
  input  logic [EXIT_W-1:0] exit_wait_i,
  input  logic [1:0]        row_sel_i,
  input  logic              init_done_i,
  input  logic              dyn_req_i,
  input  logic              dyn_busy_i,
  input  logic              st_req_i,
  output logic              dyn_gnt_o,
  output logic              st_gnt_o,
  output logic [2:0]        cmd_o,
  output logic              cke_o,
  output logic              sr_ack_o,
  output logic              init_req_o
);
  sd_cmd_e cmd;
  logic    run, fire, start, idle, pend, sr_req;

  assign sr_req = sw_sr_req_i | pmu_sr_req_i;

  sdram_ref_timer #(.REF_WINDOW(REF_WINDOW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .fire_i    (fire),
    .row_sel_i (row_sel_i),
    .pend_o    (pend)
  );

  sdram_pwr_fsm #(.EXIT_W(EXIT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .sr_req_i    (sr_req),
    .deep_i      (deep_sleep_i),
    .busy_i      (dyn_busy_i),
    .exit_wait_i (exit_wait_i),
    .ref_pend_i  (pend),
    .init_done_i (init_done_i),
    .cmd_o       (cmd),
    .cke_o       (cke_o),
    .ack_o       (sr_ack_o),
    .run_o       (run),
    .fire_o      (fire),
    .start_o     (start),
    .idle_o      (idle),
    .init_req_o  (init_req_o)
  );

  sdram_grant_gate u_gate (
    .idle_i     (idle),
    .fire_i     (fire),
    .start_i    (start),
    .init_req_i (init_req_o),
    .soft_rst_i (soft_rst_i),
    .dyn_req_i  (dyn_req_i),
    .st_req_i   (st_req_i),
    .dyn_gnt_o  (dyn_gnt_o),
    .st_gnt_o   (st_gnt_o)
  );

  assign cmd_o = cmd;

  // R2
  sref_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_SREF) |-> $past(cmd_o) == CMD_PRE_ALL);
  // R2
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_ack_o) |-> (!cke_o && $past(cmd_o) == CMD_SREF));
  // R4
  exit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cke_o) && sr_ack_o) |-> !$past(sr_req));
  // R5
  no_ref_dpd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !sr_ack_o) |-> cmd_o != CMD_AREF);
  // R5
  init_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_o |-> !dyn_gnt_o);
  // R7
  no_gnt_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_ack_o || !cke_o) |-> !dyn_gnt_o);
  // R11
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_ack_o) |-> $past(cmd_o) == CMD_AREF);
endmodule

// File: tb/tb_sdram_pwr_seq.sv
module tb_sdram_pwr_seq;
  localparam int REF_WINDOW = 65536;
  localparam int EXIT_W     = 8;
  localparam int BASE       = REF_WINDOW / 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic soft_rst = 0, sw_sr = 0, pmu_sr = 0, deep = 0, init_done = 0;
  logic dyn_req = 0, dyn_busy = 0, st_req = 0;
  logic [EXIT_W-1:0] exit_wait = '0;
  logic [1:0] row_sel = 2'd0;
  logic dyn_gnt, st_gnt, cke, ack, init_req;
  logic [2:0] cmd;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  sdram_pwr_seq #(.REF_WINDOW(REF_WINDOW), .EXIT_W(EXIT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .sw_sr_req_i(sw_sr), .pmu_sr_req_i(pmu_sr), .deep_sleep_i(deep),
    .exit_wait_i(exit_wait), .row_sel_i(row_sel), .init_done_i(init_done),
    .dyn_req_i(dyn_req), .dyn_busy_i(dyn_busy), .st_req_i(st_req),
    .dyn_gnt_o(dyn_gnt), .st_gnt_o(st_gnt), .cmd_o(cmd), .cke_o(cke),
    .sr_ack_o(ack), .init_req_o(init_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // phases: 0 idle 1 drain 2 precharge 3 sr cmd 4 sr 5 exit wait 6 exit aref 7 dpd cmd 8 dpd
  int ph = 0, tm = 0, ecnt = 0;
  bit pend = 0, minit = 1, go_dp = 0;

  function automatic int intv_of(input int rs);
    return BASE >> ((rs > 2) ? 2 : rs);
  endfunction

  function automatic bit m_fire();
    return ph == 0 && pend && !dyn_busy;
  endfunction

  function automatic bit m_start();
    return ph == 0 && !soft_rst && (deep || sw_sr || pmu_sr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; tm = 0; ecnt = 0; pend = 0; minit = 1; go_dp = 0;
    end else begin
      automatic bit run  = ph <= 2;
      automatic bit due  = run && tm >= intv_of(row_sel) - 1;
      automatic bit fire = m_fire();
      automatic bit strt = m_start();
      automatic bit sr   = sw_sr || pmu_sr;
      if (!run) begin tm = 0; pend = 0; end
      else begin
        tm = due ? 0 : tm + 1;
        if (due) pend = 1; else if (fire) pend = 0;
      end
      if (ph == 8 && !deep) minit = 1; else if (init_done) minit = 0;
      case (ph)
        0: if (strt) begin ph = 1; go_dp = deep; end
        1: if (!dyn_busy) ph = 2;
        2: ph = go_dp ? 7 : 3;
        3: ph = 4;
        4: if (!sr) begin ph = 5; ecnt = 0; end
        5: if (ecnt == int'(exit_wait)) ph = 6; else ecnt++;
        6: ph = 0;
        7: ph = 8;
        8: if (!deep) ph = 0;
        default: ph = 0;
      endcase
    end
  end

  // ---------------- monitor: compare every cycle ----------------
  int cyc = 0, aref_cnt = 0, last_aref = -1, gap = 0, rise_cyc = 0, exit_gap = -1;
  bit seen_dpd = 0, seen_ack = 0, dpd_ref = 0, prev_cke = 1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic int ecmd = (ph == 2) ? 1 : (ph == 3) ? 3 : (ph == 6) ? 2 :
                           (ph == 7) ? 4 : (ph == 0 && m_fire()) ? 2 : 0;
      automatic bit ecke = !(ph == 3 || ph == 4 || ph == 7 || ph == 8);
      automatic bit eack = ph >= 4 && ph <= 6;
      automatic bit egnt = ph == 0 && dyn_req && !minit && !soft_rst && !m_fire() && !m_start();
      chk("R2 cmd_o", cmd, ecmd);
      chk("R4 cke_o", cke, ecke);
      chk("R11 sr_ack_o", ack, eack);
      chk("R7 dyn_gnt_o", dyn_gnt, egnt);
      chk("R6 st_gnt_o", st_gnt, st_req);
      chk("R5 init_req_o", init_req, minit);
      if (cmd == 3'd2) begin
        aref_cnt++;
        if (last_aref >= 0) gap = cyc - last_aref;
        last_aref = cyc;
        if (ack) exit_gap = cyc - rise_cyc;
        if (!cke && !ack) dpd_ref = 1;
      end
      if (cmd == 3'd4) seen_dpd = 1;
      if (ack) seen_ack = 1;
      if (cke && !prev_cke) rise_cyc = cyc;
      prev_cke = cke;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int a0;
    dyn_req = 1;
    #12;
    // R1 reset state
    chk("R1 cke", cke, 1); chk("R1 cmd", cmd, 0); chk("R1 ack", ack, 0);
    chk("R1 init_req", init_req, 1); chk("R1 dyn_gnt", dyn_gnt, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R1 cke after reset", cke, 1); chk("R1 init after reset", init_req, 1);
    step(2);
    init_done = 1; step(1); init_done = 0;

    // R8 refresh interval per row select
    for (int rs = 0; rs < 4; rs++) begin
      row_sel = 2'(rs);
      step(100);
      chk("R8 refresh gap", gap, intv_of(rs));
    end

    // R10 refresh held by an open access
    row_sel = 2'd2;
    dyn_busy = 1; step(2);
    a0 = aref_cnt;
    step(30);
    chk("R10 no refresh while busy", aref_cnt, a0);
    dyn_busy = 0; step(1);
    chk("R10 refresh after busy drop", aref_cnt, a0 + 1);

    // R2 software self-refresh with drain; R4 exit wait 3
    exit_wait = 8'd3;
    dyn_busy = 1; sw_sr = 1; step(5);
    chk("R2 no ack while draining", ack, 0);
    dyn_busy = 0; step(6);
    chk("R2 ack after entry", ack, 1);
    chk("R2 cke low in self-refresh", cke, 0);
    st_req = 1; step(1);
    chk("R6 static grant in self-refresh", st_gnt, 1);
    st_req = 0; a0 = aref_cnt; step(20);
    chk("R2 no refresh in self-refresh", aref_cnt, a0);
    sw_sr = 0; step(12);
    chk("R4 exit gap", exit_gap, 4);
    chk("R11 ack cleared", ack, 0);
    step(20);

    // R2 power-manager source; R4 exit wait 0
    exit_wait = 8'd0; exit_gap = -1;
    pmu_sr = 1; step(8);
    chk("R2 pmu ack", ack, 1);
    pmu_sr = 0; step(6);
    chk("R4 exit gap zero wait", exit_gap, 1);
    step(10);

    // R3 deep sleep wins over simultaneous self-refresh; R5
    seen_dpd = 0; seen_ack = 0; dpd_ref = 0;
    deep = 1; sw_sr = 1; step(60);
    chk("R3 dpd issued", seen_dpd, 1);
    chk("R3 no ack", seen_ack, 0);
    chk("R5 cke low", cke, 0);
    chk("R5 no refresh in dpd", dpd_ref, 0);
    sw_sr = 0; step(3); deep = 0; step(3);
    chk("R5 init flag", init_req, 1);
    chk("R5 grant blocked", dyn_gnt, 0);
    chk("R5 cke back", cke, 1);
    step(10);
    init_done = 1; step(1); init_done = 0;
    step(40);
    chk("R5 init cleared", init_req, 0);

    // R9 soft reset: refresh keeps going, requests ignored
    row_sel = 2'd2; seen_ack = 0;
    soft_rst = 1; sw_sr = 1; a0 = aref_cnt;
    step(64);
    chk("R9 refresh count", aref_cnt - a0, 8);
    chk("R9 no ack", seen_ack, 0);
    chk("R9 no grant", dyn_gnt, 0);
    sw_sr = 0; step(2); soft_rst = 0; step(20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule